// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block produces the serial clock for an SPI master from the system clock. The clock is first halved. An optional fixed prescaler follows, dividing by sixteen. Next comes a programmable stage that divides by (PM+1), with PM a 4-bit value. A final toggle stage then gives a square SCK. So the SCK frequency is f_clk / 2 / ((PM+1) x 2), or that value divided again by sixteen when the prescaler is on.

Each of the four chip selects has its own divider settings: a prescale-enable bit, a PM value and a clock-invert bit. The chip-select index picks one of the four sets. The chosen set is copied into shadow registers whenever no frame is in progress, and it is frozen for the length of a frame. A new setting therefore never affects a character that is already being clocked. The shift engine next to this block watches a one-cycle strobe, which marks every SCK edge, and reads the SCK level.

Top module: `spi_baud_gen`

## Requirements
- R1: After a synchronous active-low reset, `sck_o` is 0 and `sck_tick_o` is 0.
- R2: With the prescale bit of the selected chip select clear, `sck_tick_o` pulses for one cycle every 2*(PM+1) clock cycles. The first pulse is seen 2*(PM+1) cycles after the first rising edge at which the frame and the enable are both high.
- R3: With the prescale bit set, the strobe period is 32*(PM+1) clock cycles, and the first pulse comes after the same number of cycles.
- R4: The whole PM range 0 to 15 works. PM=0 gives the shortest period and PM=15 gives sixteen times that period.
- R5: `sck_o` toggles in the same cycle as each strobe, starting from the idle level. One SCK period therefore spans two strobe intervals.
- R6: The settings for chip select i are `cs_div16_i[i]`, `cs_pm_i[4i+3:4i]` and `cs_inv_i[i]`. The 2-bit `cs_sel_i` chooses which set is used.
- R7: Outside a frame, `sck_o` equals the clock-invert bit of the selected chip select. It follows a change of selection or of that bit one cycle later.
- R8: While `en_i` is low, no strobe is produced, `sck_o` stays at its idle level and the counters are cleared. After `en_i` rises, the first strobe comes one full period later.
- R9: Changes to the selected settings, or to `cs_sel_i`, while `frame_i` is high have no effect until the next frame.
- R10: When `frame_i` falls, the counters clear and `sck_o` returns to the idle level on the next edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Interface enable; clears the counters while low |
| frame_i | input | 1 | High for the duration of a frame |
| cs_sel_i | input | 2 | Index of the active chip select |
| cs_div16_i | input | 4 | Prescale-enable bit for each chip select |
| cs_pm_i | input | 16 | 4-bit PM value for each chip select |
| cs_inv_i | input | 4 | Clock-invert (idle high) bit for each chip select |
| sck_tick_o | output | 1 | One-cycle strobe at each SCK edge |
| sck_o | output | 1 | Serial clock level |

## Verification
A wrong internal count shows up as a strobe that arrives early or late. The first strobe of a frame comes exactly one period after the frame starts, so a count error is visible within one period, which is at most 512 cycles. A shadow register that fails to hold shows up as a change in period in the middle of a frame. A phase or idle error shows up as a wrong `sck_o` level, either at the next strobe or one cycle after the frame ends. The bench predicts the cycle and the SCK level of every strobe from the settings alone, and it treats any strobe it did not predict as an error.

// File: rtl/spi_baud_pkg.sv
// Shared defaults for the SPI serial clock rate generator.
// Assumes: consumers derive every width from these values.
package spi_baud_pkg;
    localparam int DEF_NUM_CS    = 4;   // chip selects with their own settings
    localparam int DEF_PM_W      = 4;   // width of the programmable divide value
    localparam int DEF_PRE_RATIO = 16;  // ratio of the optional prescaler
endpackage

// File: rtl/spi_baud_cfg_sel.sv
// Picks the divider settings of the active chip select and keeps a shadow copy.
// Assumes: the shadow reloads on every edge outside a frame and stays frozen inside one.
module spi_baud_cfg_sel #(
    parameter int NUM_CS = 4,
    parameter int PM_W   = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_i,
    input  logic [CS_W-1:0]        cs_sel_i,
    input  logic [NUM_CS-1:0]      cs_div16_i,
    input  logic [NUM_CS*PM_W-1:0] cs_pm_i,
    input  logic [NUM_CS-1:0]      cs_inv_i,
    output logic                   div16_q,
    output logic [PM_W-1:0]        pm_q,
    output logic                   inv_q
);
    // Reload the shadow set from the selected chip select whenever no frame is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div16_q <= 1'b0;
            pm_q    <= '0;
            inv_q   <= 1'b0;
        end else if (!frame_i) begin
            div16_q <= cs_div16_i[cs_sel_i];
            pm_q    <= cs_pm_i[int'(cs_sel_i)*PM_W +: PM_W];
            inv_q   <= cs_inv_i[cs_sel_i];
        end
    end

    // R9: settings stay frozen while a frame is running
    p_shadow_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> ($stable(pm_q) && $stable(div16_q) && $stable(inv_q)));
endmodule

// File: rtl/spi_baud_prescale.sv
// First part of the chain: a fixed halving stage, then an optional divide-by-PRE_RATIO.
// Assumes: run_i low clears every stage; div16_i is constant while run_i is high.
module spi_baud_prescale #(
    parameter int PRE_RATIO = 16,
    localparam int PRE_W    = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic div16_i,
    output logic pulse_o
);
    logic half_q;
    logic half_pulse;

    // Halve the system clock: one pulse every second enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) half_q <= 1'b0;
        else                  half_q <= ~half_q;
    end

    assign half_pulse = run_i & half_q;

    generate
        if (PRE_RATIO > 1) begin : g_pre
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);
            logic [PRE_W-1:0] pre_q;

            // Count halved pulses when the prescaler is on, wrapping at the ratio.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i)            pre_q <= '0;
                else if (half_pulse && div16_i)  pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            end

            assign pulse_o = half_pulse & (!div16_i || (pre_q == PRE_LAST));

            // R2: the prescale counter stays idle when the prescaler is off
            p_pre_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!div16_i && !$past(div16_i)) |-> (pre_q == '0));
        end else begin : g_nopre
            assign pulse_o = half_pulse;
        end
    endgenerate

    // R3: the prescaled output never fires on two cycles in a row
    p_pulse_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/spi_baud_divider.sv
// Programmable (PM+1) divider plus the final toggle stage that gives a square SCK.
// Assumes: pm_i and inv_i are constant while run_i is high.
module spi_baud_divider #(
    parameter int PM_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            pulse_i,
    input  logic [PM_W-1:0] pm_i,
    input  logic            inv_i,
    output logic            tick_o,
    output logic            sck_o
);
    logic [PM_W-1:0] cnt_q;
    logic            phase_q;
    logic            tick_q;
    logic            term;

    assign term = pulse_i && (cnt_q == pm_i);

    // Count prescaled pulses; at the terminal count, strobe and flip the SCK phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= term;
            if (pulse_i) cnt_q <= term ? '0 : cnt_q + 1'b1;
            if (term)    phase_q <= ~phase_q;
        end
    end

    assign tick_o = tick_q;
    assign sck_o  = inv_i ^ phase_q;

    // R4: the count never passes the programmed divide value
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= pm_i);
    // R5: every strobe comes with a change of the SCK phase
    p_toggle_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_q) |-> (phase_q != $past(phase_q)));
    // R10: a stopped divider returns SCK to idle and stays quiet
    p_idle_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ((sck_o == inv_i) && !tick_o));
endmodule

// File: rtl/spi_baud_gen.sv
// Top of the SPI serial clock rate generator: settings select, prescaler, divider.
// Assumes: frame_i is driven by the shift engine and brackets every frame.
module spi_baud_gen
    import spi_baud_pkg::*;
#(
    parameter int NUM_CS    = DEF_NUM_CS,
    parameter int PM_W      = DEF_PM_W,
    parameter int PRE_RATIO = DEF_PRE_RATIO,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic                   frame_i,
    input  logic [CS_W-1:0]        cs_sel_i,
    input  logic [NUM_CS-1:0]      cs_div16_i,
    input  logic [NUM_CS*PM_W-1:0] cs_pm_i,
    input  logic [NUM_CS-1:0]      cs_inv_i,
    output logic                   sck_tick_o,
    output logic                   sck_o
);
    logic            run;
    logic            div16_s;
    logic [PM_W-1:0] pm_s;
    logic            inv_s;
    logic            pre_pulse;

    assign run = en_i & frame_i;

    spi_baud_cfg_sel #(.NUM_CS(NUM_CS), .PM_W(PM_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_i),
        .cs_sel_i   (cs_sel_i),
        .cs_div16_i (cs_div16_i),
        .cs_pm_i    (cs_pm_i),
        .cs_inv_i   (cs_inv_i),
        .div16_q    (div16_s),
        .pm_q       (pm_s),
        .inv_q      (inv_s)
    );

    spi_baud_prescale #(.PRE_RATIO(PRE_RATIO)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .div16_i (div16_s),
        .pulse_o (pre_pulse)
    );

    spi_baud_divider #(.PM_W(PM_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .pulse_i (pre_pulse),
        .pm_i    (pm_s),
        .inv_i   (inv_s),
        .tick_o  (sck_tick_o),
        .sck_o   (sck_o)
    );

    // R8: no strobe follows a cycle with the interface disabled
    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sck_tick_o);
endmodule

// File: tb/spi_baud_gen_bench.sv
// Scoreboard bench: driver tasks queue the predicted strobes, a monitor checks them.
module spi_baud_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        frame = 1'b0;
    logic [1:0]  cs_sel = 2'd0;
    logic [3:0]  div16_v;
    logic [15:0] pm_v;
    logic [3:0]  inv_v;
    logic        tick;
    logic        sck;

    logic [3:0] pm_a [4];
    bit         d16_a [4];
    bit         inv_a [4];

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    int    exp_cyc [$];
    bit    exp_lvl [$];
    string exp_tag [$];

    always #10ns clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Pack the per-chip-select settings onto the input buses.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            div16_v[i]         = d16_a[i];
            pm_v[4*i +: 4]     = pm_a[i];
            inv_v[i]           = inv_a[i];
        end
    end

    spi_baud_gen u_spi_baud_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .frame_i    (frame),
        .cs_sel_i   (cs_sel),
        .cs_div16_i (div16_v),
        .cs_pm_i    (pm_v),
        .cs_inv_i   (inv_v),
        .sck_tick_o (tick),
        .sck_o      (sck)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int period(input int cs);
        return 2 * (pm_a[cs] + 1) * (d16_a[cs] ? 16 : 1);
    endfunction

    // Monitor: every strobe must match the head of the queue in cycle and level.
    always @(negedge clk) begin
        if (rst_n && tick) begin
            n_cmp++;
            if (exp_cyc.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected strobe actual cycle=%0d expected=none", cyc);
            end else begin
                int    ec;
                bit    el;
                string et;
                ec = exp_cyc.pop_front();
                el = exp_lvl.pop_front();
                et = exp_tag.pop_front();
                if (ec != cyc || el != sck) begin
                    n_bad++;
                    $display("FAIL %s strobe actual cycle=%0d sck=%0b expected cycle=%0d sck=%0b",
                             et, cyc, sck, ec, el);
                end
            end
        end
    end

    // Drive one frame of k strobes on chip select cs; optionally alter settings mid-frame.
    task automatic run_frame(input int cs, input int k, input string tag, input bit perturb);
        int n;
        int c0;
        @(negedge clk);
        cs_sel = 2'(cs);
        @(negedge clk);
        check("R7 idle level", int'(sck), int'(inv_a[cs]));
        n = period(cs);
        frame = 1'b1;
        c0 = cyc;
        for (int j = 1; j <= k; j++) begin
            exp_cyc.push_back(c0 + n * j);
            exp_lvl.push_back(inv_a[cs] ^ j[0]);
            exp_tag.push_back(tag);
        end
        repeat (n) @(negedge clk);
        if (perturb) begin
            // R9: these changes must not alter the running frame
            pm_a[cs]  = pm_a[cs] ^ 4'hA;
            d16_a[cs] = ~d16_a[cs];
            inv_a[cs] = ~inv_a[cs];
            cs_sel    = 2'(cs + 1);
        end
        repeat (n * (k - 1)) @(negedge clk);
        frame = 1'b0;
        @(negedge clk);
        check({tag, " all strobes seen"}, exp_cyc.size(), 0);
        check("R10 strobe clear after frame", int'(tick), 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            pm_a[i] = 4'd0; d16_a[i] = 1'b0; inv_a[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sck after reset", int'(sck), 0);
        check("R1 strobe after reset", int'(tick), 0);
        rst_n = 1'b1;
        en = 1'b1;
        @(negedge clk);
        check("R1 sck idle after release", int'(sck), 0);

        // R2, R4: fastest setting, PM=0
        run_frame(0, 4, "R2 pm0", 1'b0);
        // R6: other chip selects carry their own settings
        pm_a[1] = 4'd5; pm_a[3] = 4'd15; d16_a[3] = 1'b1;
        pm_a[2] = 4'd3; d16_a[2] = 1'b1; inv_a[2] = 1'b1;
        run_frame(1, 3, "R6 cs1 pm5", 1'b0);
        // R3, R7: prescaled, idle high
        run_frame(2, 3, "R3 cs2 div16 inv", 1'b0);
        // R4: largest divide value with the prescaler
        run_frame(3, 2, "R4 cs3 pm15 div16", 1'b0);
        pm_a[0] = 4'd15;
        run_frame(0, 3, "R4 cs0 pm15", 1'b0);

        // R9: mid-frame changes deferred, then used in the next frame
        run_frame(1, 3, "R9 frozen", 1'b1);
        run_frame(1, 2, "R9 new settings", 1'b0);

        // R7: idle level follows the selected invert bit one cycle later
        @(negedge clk);
        cs_sel = 2'd2;
        inv_a[2] = 1'b1;
        @(negedge clk);
        check("R7 idle high", int'(sck), 1);
        inv_a[2] = 1'b0;
        @(negedge clk);
        check("R7 idle follows bit", int'(sck), 0);

        // R8: disable in the middle of a frame, then restart from a full period
        begin
            int n;
            int c1;
            pm_a[0] = 4'd2; d16_a[0] = 1'b0; inv_a[0] = 1'b1;
            cs_sel = 2'd0;
            @(negedge clk);
            n = period(0);
            frame = 1'b1;
            exp_cyc.push_back(cyc + n);
            exp_lvl.push_back(1'b0);
            exp_tag.push_back("R8 before disable");
            repeat (n + 2) @(negedge clk);
            en = 1'b0;
            repeat (2 * n) @(negedge clk);
            check("R8 sck idle while disabled", int'(sck), 1);
            check("R8 no strobe while disabled", int'(tick), 0);
            en = 1'b1;
            c1 = cyc;
            for (int j = 1; j <= 2; j++) begin
                exp_cyc.push_back(c1 + n * j);
                exp_lvl.push_back(~j[0]);
                exp_tag.push_back("R8 after enable");
            end
            repeat (2 * n) @(negedge clk);
            frame = 1'b0;
            @(negedge clk);
            check("R8 all strobes seen", exp_cyc.size(), 0);
            check("R10 sck idle after frame", int'(sck), 1);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule